// File: doc/BRIEF.md
# Dual-Port Hardware Semaphore Bank

This block holds a small bank of binary tokens that two independent agents, a left port and a right port, use to negotiate ownership of shared resources in software. Each token sits in an address space of its own, reached through a per-port semaphore select, and is wholly apart from any data storage. A port asks for a token by writing a zero to it and gives it up by writing a one. It then reads the token back to learn whether it won. Only bit 0 of the write data and the low address bits that index the bank matter. All other bits are ignored.

Every token keeps one request latch per side and an ownership state that names at most one owner. A request from the side that does not own the token is held as a pending request. When the owner releases, ownership passes at once to the waiting side, with no further write needed. Reads are active low and spread the flag over the whole data byte. The value read is captured when the read starts and held for as long as the read stays active, so a token cannot change under a reader in the middle of a cycle.

Top module: `sema_bank_top`

## Requirements
- R1: After reset every token is free, and a read of any token from either side returns 8'hFF.
- R2: The token index is the low 3 address bits. Address bits above bit 2 have no effect, so a write at address 6'h09 acts on token 1.
- R3: A write is a cycle with `*_sem_sel`=1 and `*_wr_en`=1. Only write-data bit 0 is used: bit 0 = 0 requests the token and bit 0 = 1 releases that side's request. The other data bits are ignored.
- R4: A read is a cycle with `*_sem_sel`=1, `*_out_en`=1 and `*_wr_en`=0. The owning side reads 8'h00. The other side, and both sides of a free token, read 8'hFF. The flag value appears on all eight bits.
- R5: A request to a free token makes that side the owner. When both sides request a free token in the same cycle, the left side becomes the owner.
- R6: A request from the non-owning side is held as pending. When the owner releases, the pending side becomes owner at the same clock edge.
- R7: Only the owner's release changes ownership. Writes from the non-owner never take the token. A non-owner writing 1 withdraws its pending request, so a later release by the owner leaves the token free.
- R8: Read data is captured at the first clock edge of an active read. It stays unchanged while the read stays active, even if ownership changes, and it is captured again only after select or output enable has gone inactive.
- R9: A write takes effect at the clock edge that ends its cycle. A read started in the following cycle observes the new ownership, and `*_rdata` is valid from that read's capture edge onward.
- R10: The tokens are independent: activity on one token never changes the state of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| l_sem_sel | input | 1 | Left port semaphore select |
| l_out_en | input | 1 | Left port output enable |
| l_wr_en | input | 1 | Left port write (1) / read (0) |
| l_addr | input | PORT_ADDR_W | Left port address, low 3 bits index the token |
| l_wdata | input | DATA_W | Left port write data, bit 0 used |
| l_rdata | output | DATA_W | Left port captured read data |
| r_sem_sel | input | 1 | Right port semaphore select |
| r_out_en | input | 1 | Right port output enable |
| r_wr_en | input | 1 | Right port write (1) / read (0) |
| r_addr | input | PORT_ADDR_W | Right port address, low 3 bits index the token |
| r_wdata | input | DATA_W | Right port write data, bit 0 used |
| r_rdata | output | DATA_W | Right port captured read data |

## Verification
A corrupted ownership state shows up as a wrong byte on the next fresh read from either side. Examples are two owners at once, a pending request that was dropped, or a token handed over without a release. Each ownership scenario is therefore followed by reads from both ports one cycle after the causing write. A frozen-read failure shows up within one cycle: a held read whose byte changes after a handover that happened during the hold. The tie and withdraw cases are each followed by a release, so that a hidden wrong latch value becomes visible as a wrong owner.

// File: rtl/sema_pkg.sv
`timescale 1ns/1ps
package sema_pkg;

    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } owner_e;

    // Request latches are active low: 1 means no request from that side.
    typedef struct packed {
        logic   req_l_n;
        logic   req_r_n;
        owner_e owner;
    } sem_state_t;

    localparam sem_state_t SEM_RESET = '{req_l_n: 1'b1, req_r_n: 1'b1, owner: OWN_NONE};

endpackage

// File: rtl/sema_port_dec.sv
`timescale 1ns/1ps
module sema_port_dec #(
    parameter int NUM_SEM     = 8,
    parameter int PORT_ADDR_W = 6,
    parameter int DATA_W      = 8,
    localparam int IDX_W      = $clog2(NUM_SEM)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sem_sel,
    input  logic                   wr_en,
    input  logic [PORT_ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0]      wdata,
    output logic [NUM_SEM-1:0]     wr_vec,
    output logic [IDX_W-1:0]       idx,
    output logic                   wr_bit
);

    logic unused_bits;

    always_comb begin
        idx    = addr[IDX_W-1:0];
        wr_bit = wdata[0];
        wr_vec = '0;
        if (sem_sel && wr_en) begin
            wr_vec[idx] = 1'b1;
        end
    end

    assign unused_bits = ^{addr[PORT_ADDR_W-1:IDX_W], wdata[DATA_W-1:1]};

    // R2: a write strobes at most one token
    assert_one_token_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_vec));

    // R3: no strobe without select and write enable
    assert_strobe_needs_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(sem_sel && wr_en) |-> (wr_vec == '0));

endmodule

// File: rtl/sema_cell.sv
`timescale 1ns/1ps
module sema_cell
    import sema_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_l,
    input  logic bit_l,
    input  logic wr_r,
    input  logic bit_r,
    output logic flag_l,
    output logic flag_r
);

    sem_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_l) st_d.req_l_n = bit_l;
        if (wr_r) st_d.req_r_n = bit_r;
        case (st_q.owner)
            OWN_NONE: begin
                if (!st_d.req_l_n)      st_d.owner = OWN_LEFT;
                else if (!st_d.req_r_n) st_d.owner = OWN_RIGHT;
            end
            OWN_LEFT: begin
                if (st_d.req_l_n) st_d.owner = st_d.req_r_n ? OWN_NONE : OWN_RIGHT;
            end
            OWN_RIGHT: begin
                if (st_d.req_r_n) st_d.owner = st_d.req_l_n ? OWN_NONE : OWN_LEFT;
            end
            default: st_d.owner = OWN_NONE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SEM_RESET;
        else        st_q <= st_d;
    end

    assign flag_l = (st_q.owner != OWN_LEFT);
    assign flag_r = (st_q.owner != OWN_RIGHT);

    // R6: an owner always holds its own request
    assert_owner_holds_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.owner == OWN_LEFT) |-> !st_q.req_l_n) and
        ((st_q.owner == OWN_RIGHT) |-> !st_q.req_r_n));

    // R5: a free token has no pending request left over
    assert_free_no_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.owner == OWN_NONE) |-> (st_q.req_l_n && st_q.req_r_n));

    // R5: same-cycle requests on a free token go to the left side
    assert_tie_left_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.owner == OWN_NONE && wr_l && !bit_l && wr_r && !bit_r) |=> (st_q.owner == OWN_LEFT));

    // R6: release by the left owner hands over to a waiting right side
    assert_handover_l2r_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.owner == OWN_LEFT && wr_l && bit_l && !st_q.req_r_n && !wr_r) |=> (st_q.owner == OWN_RIGHT));

    // R6: release by the right owner hands over to a waiting left side
    assert_handover_r2l_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.owner == OWN_RIGHT && wr_r && bit_r && !st_q.req_l_n && !wr_l) |=> (st_q.owner == OWN_LEFT));

    // R7: without its own release the owner keeps the token
    assert_no_steal_left_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.owner == OWN_LEFT && !(wr_l && bit_l)) |=> (st_q.owner == OWN_LEFT));

    assert_no_steal_right_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.owner == OWN_RIGHT && !(wr_r && bit_r)) |=> (st_q.owner == OWN_RIGHT));

endmodule

// File: rtl/sema_rd_port.sv
`timescale 1ns/1ps
module sema_rd_port #(
    parameter int NUM_SEM = 8,
    parameter int DATA_W  = 8,
    localparam int IDX_W  = $clog2(NUM_SEM)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sem_sel,
    input  logic               out_en,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   idx,
    input  logic [NUM_SEM-1:0] flags,
    output logic [DATA_W-1:0]  rdata
);

    typedef struct packed {
        logic              act;
        logic [DATA_W-1:0] data;
    } rd_state_t;

    rd_state_t rd_d, rd_q;
    logic      rd_act;

    always_comb begin
        rd_act     = sem_sel && out_en && !wr_en;
        rd_d       = rd_q;
        rd_d.act   = rd_act;
        if (rd_act && !rd_q.act) begin
            rd_d.data = {DATA_W{flags[idx]}};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q.act  <= 1'b0;
            rd_q.data <= '1;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rdata = rd_q.data;

    // R8: a held read keeps its captured byte
    assert_read_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_act && rd_q.act) |=> $stable(rdata));

    // R4: the flag is spread over every data bit
    assert_flag_spread_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(rdata) == 0) || ($countones(rdata) == DATA_W));

endmodule

// File: rtl/sema_bank_top.sv
`timescale 1ns/1ps
module sema_bank_top #(
    parameter int NUM_SEM     = 8,
    parameter int PORT_ADDR_W = 6,
    parameter int DATA_W      = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   l_sem_sel,
    input  logic                   l_out_en,
    input  logic                   l_wr_en,
    input  logic [PORT_ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0]      l_wdata,
    output logic [DATA_W-1:0]      l_rdata,
    input  logic                   r_sem_sel,
    input  logic                   r_out_en,
    input  logic                   r_wr_en,
    input  logic [PORT_ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0]      r_wdata,
    output logic [DATA_W-1:0]      r_rdata
);

    localparam int IDX_W = $clog2(NUM_SEM);

    logic [NUM_SEM-1:0] wvec_l, wvec_r;
    logic [NUM_SEM-1:0] flags_l, flags_r;
    logic [IDX_W-1:0]   idx_l, idx_r;
    logic               bit_l, bit_r;

    sema_port_dec #(.NUM_SEM(NUM_SEM), .PORT_ADDR_W(PORT_ADDR_W), .DATA_W(DATA_W)) u_dec_l (
        .clk(clk), .rst_n(rst_n), .sem_sel(l_sem_sel), .wr_en(l_wr_en),
        .addr(l_addr), .wdata(l_wdata), .wr_vec(wvec_l), .idx(idx_l), .wr_bit(bit_l)
    );

    sema_port_dec #(.NUM_SEM(NUM_SEM), .PORT_ADDR_W(PORT_ADDR_W), .DATA_W(DATA_W)) u_dec_r (
        .clk(clk), .rst_n(rst_n), .sem_sel(r_sem_sel), .wr_en(r_wr_en),
        .addr(r_addr), .wdata(r_wdata), .wr_vec(wvec_r), .idx(idx_r), .wr_bit(bit_r)
    );

    for (genvar g = 0; g < NUM_SEM; g++) begin : g_cell
        sema_cell u_cell (
            .clk(clk), .rst_n(rst_n),
            .wr_l(wvec_l[g]), .bit_l(bit_l),
            .wr_r(wvec_r[g]), .bit_r(bit_r),
            .flag_l(flags_l[g]), .flag_r(flags_r[g])
        );
    end

    sema_rd_port #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) u_rd_l (
        .clk(clk), .rst_n(rst_n), .sem_sel(l_sem_sel), .out_en(l_out_en), .wr_en(l_wr_en),
        .idx(idx_l), .flags(flags_l), .rdata(l_rdata)
    );

    sema_rd_port #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) u_rd_r (
        .clk(clk), .rst_n(rst_n), .sem_sel(r_sem_sel), .out_en(r_out_en), .wr_en(r_wr_en),
        .idx(idx_r), .flags(flags_r), .rdata(r_rdata)
    );

    // R5: never two owners of one token
    assert_single_owner_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_l | flags_r) == '1);

endmodule

// File: tb/sema_bank_top_tb.sv
`timescale 1ns/1ps
module sema_bank_top_tb;

    localparam bit LEFT  = 1'b0;
    localparam bit RIGHT = 1'b1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       l_sem_sel = 0, l_out_en = 0, l_wr_en = 0;
    logic [5:0] l_addr = '0;
    logic [7:0] l_wdata = '0;
    logic [7:0] l_rdata;
    logic       r_sem_sel = 0, r_out_en = 0, r_wr_en = 0;
    logic [5:0] r_addr = '0;
    logic [7:0] r_wdata = '0;
    logic [7:0] r_rdata;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    typedef struct {
        bit       side;
        bit [7:0] exp;
        string    tag;
    } item_t;
    item_t sb_q[$];

    always #4 clk = ~clk;

    sema_bank_top u_dut (
        .clk(clk), .rst_n(rst_n),
        .l_sem_sel(l_sem_sel), .l_out_en(l_out_en), .l_wr_en(l_wr_en),
        .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
        .r_sem_sel(r_sem_sel), .r_out_en(r_out_en), .r_wr_en(r_wr_en),
        .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic idle(input bit side);
        if (side == LEFT) begin l_sem_sel = 0; l_out_en = 0; l_wr_en = 0; end
        else              begin r_sem_sel = 0; r_out_en = 0; r_wr_en = 0; end
    endtask

    task automatic set_wr(input bit side, input logic [5:0] a, input logic [7:0] d);
        if (side == LEFT) begin l_sem_sel = 1; l_wr_en = 1; l_out_en = 0; l_addr = a; l_wdata = d; end
        else              begin r_sem_sel = 1; r_wr_en = 1; r_out_en = 0; r_addr = a; r_wdata = d; end
    endtask

    task automatic set_rd(input bit side, input logic [5:0] a);
        if (side == LEFT) begin l_sem_sel = 1; l_wr_en = 0; l_out_en = 1; l_addr = a; end
        else              begin r_sem_sel = 1; r_wr_en = 0; r_out_en = 1; r_addr = a; end
    endtask

    // driver: push an expected byte for the next monitor sample
    task automatic expect_rd(input bit side, input bit [7:0] exp, input string tag);
        item_t it;
        it.side = side; it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic wr(input bit side, input logic [5:0] a, input logic [7:0] d);
        set_wr(side, a, d);
        tick();
        idle(side);
    endtask

    // one-cycle read: capture edge, expectation, then a gap cycle
    task automatic rd(input bit side, input logic [5:0] a, input bit [7:0] exp, input string tag);
        set_rd(side, a);
        tick();
        expect_rd(side, exp, tag);
        idle(side);
        tick();
    endtask

    // monitor: compares between edges
    initial begin
        forever begin
            @(posedge clk);
            #2;
            while (sb_q.size() > 0) begin
                item_t it;
                logic [7:0] act;
                it  = sb_q.pop_front();
                act = (it.side == LEFT) ? l_rdata : r_rdata;
                n_checks++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s side=%s actual=%02h expected=%02h", it.tag,
                             it.side ? "right" : "left", act, it.exp);
                end
            end
        end
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        tick();
        tick();
        rst_n = 1;
        tick();

        // R1: every token free after reset, both sides
        for (int i = 0; i < 8; i++) begin
            rd(LEFT,  6'(i), 8'hFF, "R1 reset left");
            rd(RIGHT, 6'(i), 8'hFF, "R1 reset right");
        end

        // R2 R9: left requests token 1 through address 6'h09, read next cycle
        wr(LEFT, 6'h09, 8'h00);
        rd(LEFT,  6'h01, 8'h00, "R9 R4 owner reads zero next cycle");
        rd(RIGHT, 6'h21, 8'hFF, "R2 R4 other side reads ones");

        // R3: right request with 8'h02 (bit 0 = 0) becomes pending, R7 no steal
        wr(RIGHT, 6'h01, 8'h02);
        rd(LEFT,  6'h01, 8'h00, "R7 owner keeps token");
        rd(RIGHT, 6'h01, 8'hFF, "R6 pending side not owner");

        // R6: left release with 8'hFD... bit0=1 -> 8'hFF variant uses bit 0 only
        wr(LEFT, 6'h01, 8'h01);
        rd(RIGHT, 6'h01, 8'h00, "R6 handover to waiting side");
        rd(LEFT,  6'h01, 8'hFF, "R6 old owner released");

        // R7: left pends then withdraws; right release leaves token free
        wr(LEFT, 6'h01, 8'hFE);
        wr(LEFT, 6'h01, 8'h01);
        wr(RIGHT, 6'h01, 8'hFF);
        rd(LEFT,  6'h01, 8'hFF, "R7 withdrawn request not granted");
        rd(RIGHT, 6'h01, 8'hFF, "R7 token free after release");

        // R5: simultaneous request on token 5, left wins
        set_wr(LEFT, 6'h05, 8'h00);
        set_wr(RIGHT, 6'h05, 8'h00);
        tick();
        idle(LEFT); idle(RIGHT);
        rd(LEFT,  6'h05, 8'h00, "R5 tie goes left");
        rd(RIGHT, 6'h05, 8'hFF, "R5 tie right loses");
        wr(RIGHT, 6'h05, 8'h01);
        wr(LEFT,  6'h05, 8'h01);
        rd(RIGHT, 6'h05, 8'hFF, "R5 R7 token free after tie release");

        // R5: first requester wins on token 6, left pends
        wr(RIGHT, 6'h06, 8'h00);
        wr(LEFT,  6'h06, 8'h00);
        rd(RIGHT, 6'h06, 8'h00, "R5 first requester owns");
        rd(LEFT,  6'h06, 8'hFF, "R5 later requester waits");

        // R10: token 0 taken by left independently of token 6
        wr(LEFT, 6'h00, 8'h00);
        rd(LEFT,  6'h00, 8'h00, "R10 token 0 owned by left");
        rd(RIGHT, 6'h06, 8'h00, "R10 token 6 unchanged");
        rd(RIGHT, 6'h07, 8'hFF, "R10 token 7 untouched");

        // R8: left holds a read on token 6 while right releases
        set_rd(LEFT, 6'h06);
        tick();
        expect_rd(LEFT, 8'hFF, "R8 captured at start of hold");
        set_wr(RIGHT, 6'h06, 8'h01);
        tick();
        idle(RIGHT);
        expect_rd(LEFT, 8'hFF, "R8 frozen across handover");
        tick();
        expect_rd(LEFT, 8'hFF, "R8 still frozen");
        idle(LEFT);
        tick();
        rd(LEFT,  6'h06, 8'h00, "R8 R6 fresh read sees new owner");
        rd(RIGHT, 6'h06, 8'hFF, "R6 releasing side reads ones");

        tick();
        tick();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule